// File: doc/BRIEF.md
# Serial Composite-Field Multiplier over GF((2^13)^23)

This block multiplies two 299-bit field elements, each held as 23 coefficients from the ground field GF(2^13). Only one 13-bit ground-field multiplier is built. A sequencer walks through every pair of coefficients, one pair per cycle. Each 13-bit product is added by XOR into one of 45 partial-sum registers, chosen by the sum of the two coefficient indices. When all pairs are done, the degree-44 intermediate is folded down to degree 22. The fold uses the extension modulus x^23 + x^5 + 1 and works from the highest coefficient downward.

A caller places both operands on the inputs and pulses `start` for one cycle. The operands are captured at that edge. `busy` then stays high while the products and the fold run. `done` pulses for one cycle when the result is ready, and the result stays on `product` until the next accepted start. The ground multiplier sits behind a valid/ready handshake, so a different ground multiplier can be fitted without changing the sequencer.

Top module: `cfm_mul299`

## Requirements
- R1: After reset, `busy` and `done` are low and `product` is all zeros.
- R2: Coefficient i of `op_a`, `op_b` and `product` occupies bits [13i+12:13i], with i from 0 to 22. Bit b of a coefficient is the weight of x^b in GF(2^13), and coefficient i is the weight of y^i in the extension.
- R3: Ground-field products are reduced by x^13 + x^4 + x^3 + x + 1. For example, the coefficient 0x1000 times the coefficient 0x0002 gives 0x001B.
- R4: Extension products are reduced by y^23 + y^5 + 1. For example, y^22 times y^22 gives y^21 + y^8 + y^3, each with coefficient 1. After the fold, every partial-sum register above degree 22 is zero.
- R5: For any operands, `product` equals the full field product of `op_a` and `op_b` as captured at the accepted start.
- R6: One ground-field product is issued per cycle. Exactly 23*23 = 529 products are issued for each multiplication, and none is delivered outside a run.
- R7: `done` goes high exactly 553 cycles after the clock edge that accepts `start` (N*N + N + 1 with N = 23). It stays high for one cycle only.
- R8: `busy` is high from the cycle after the accepting edge until the cycle before `done`, and it is low while `done` is high.
- R9: A `start` pulse while `busy` is high is ignored. Changes on `op_a` or `op_b` after the accepting edge do not affect the run in progress.
- R10: After `done`, `product` holds its value until the next accepted start, whatever happens on the operand inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; accepted only when the block is idle |
| op_a | input | 299 | First operand, 23 packed 13-bit coefficients |
| op_b | input | 299 | Second operand, 23 packed 13-bit coefficients |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when `product` is valid |
| product | output | 299 | Reduced field product, 23 packed 13-bit coefficients |

## Verification
The result is due 553 cycles after the accepting edge. That is 529 issue cycles, one cycle to drain the ground multiplier, 22 fold cycles, and the cycle that presents `done`. The bench drives inputs on the falling edge and counts falling edges from the accepting edge. It requires `done` at a count of exactly 553 and `busy` high at a count of 1. The result is compared on the cycle `done` is high, and again one cycle and several cycles later, to check that the pulse ends and that the value holds. In the test that pulses `start` mid-run, the bench checks that the latency still counts from the first accepting edge and that the result belongs to the first operand pair.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int          GW     = 13;
  localparam int          NCOEF  = 23;
  localparam int          EXTTAP = 5;
  localparam logic [12:0] GPOLY  = 13'h001B;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_FLUSH,
    ST_REDUCE,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/cfm_ground_mul.sv
module cfm_ground_mul #(
  parameter int           W    = 13,
  parameter logic [W-1:0] POLY = 13'h001B,
  parameter int           TW   = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [TW-1:0] in_tag,
  output logic         out_valid,
  output logic [W-1:0] out_prod,
  output logic [TW-1:0] out_tag
);
  // Shift-and-add multiply in GF(2^W), reducing the shifted operand each step.
  function automatic logic [W-1:0] gf_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] acc;
    logic [W-1:0] sh;
    acc = '0;
    sh  = x;
    for (int n = 0; n < W; n++) begin
      if (y[n]) acc = acc ^ sh;
      sh = {sh[W-2:0], 1'b0} ^ (sh[W-1] ? POLY : '0);
    end
    return acc;
  endfunction

  // One-cycle pipeline: a new pair is taken every cycle.
  assign in_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= in_valid && in_ready;
      if (in_valid && in_ready) begin
        out_prod <= gf_mul(in_a, in_b);
        out_tag  <= in_tag;
      end
    end
  end
endmodule

// File: rtl/cfm_pair_seq.sv
module cfm_pair_seq
  import cfm_pkg::*;
#(
  parameter int N  = 23,
  parameter int IW = $clog2(N),
  parameter int KW = $clog2(2*N-1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mul_ready,
  input  logic          mul_out_valid,
  output logic          accept,
  output logic          iss_valid,
  output logic [IW-1:0] iss_i,
  output logic [IW-1:0] iss_j,
  output logic [KW-1:0] iss_k,
  output logic          red_en,
  output logic [KW-1:0] red_k,
  output logic          busy,
  output logic          done
);
  seq_state_t    state;
  logic [IW-1:0] i_q, j_q;
  logic [KW-1:0] r_q;
  logic          last_pair;

  assign accept    = start && (state == ST_IDLE);
  assign iss_valid = (state == ST_ISSUE);
  assign iss_i     = i_q;
  assign iss_j     = j_q;
  assign iss_k     = KW'(i_q) + KW'(j_q);
  assign last_pair = (i_q == IW'(N-1)) && (j_q == IW'(N-1));
  assign red_en    = (state == ST_REDUCE);
  assign red_k     = r_q;
  assign busy      = (state == ST_ISSUE) || (state == ST_FLUSH) || (state == ST_REDUCE);
  assign done      = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      i_q   <= '0;
      j_q   <= '0;
      r_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_ISSUE;
          i_q   <= '0;
          j_q   <= '0;
        end
        ST_ISSUE: if (mul_ready) begin
          if (last_pair) begin
            state <= ST_FLUSH;
          end else if (j_q == IW'(N-1)) begin
            j_q <= '0;
            i_q <= i_q + 1'b1;
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        ST_FLUSH: if (mul_out_valid) begin
          state <= ST_REDUCE;
          r_q   <= KW'(2*N-2);
        end
        ST_REDUCE: begin
          if (r_q == KW'(N)) state <= ST_DONE;
          else               r_q   <= r_q - 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfm_coeff_acc.sv
module cfm_coeff_acc #(
  parameter int W   = 13,
  parameter int N   = 23,
  parameter int TAP = 5,
  parameter int KW  = $clog2(2*N-1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc_en,
  input  logic [KW-1:0] acc_k,
  input  logic [W-1:0]  acc_val,
  input  logic          red_en,
  input  logic [KW-1:0] red_k,
  output logic [N*W-1:0] coef_lo,
  output logic          hi_zero
);
  localparam int NC = 2*N - 1;

  logic [W-1:0]  c [NC];
  logic [W-1:0]  fold;
  logic [KW-1:0] lo_idx, mid_idx;

  // y^k = y^(k-N) * (y^TAP + 1): fold into k-N and k-N+TAP.
  always_comb begin
    fold    = c[red_k];
    lo_idx  = red_k - KW'(N);
    mid_idx = red_k - KW'(N - TAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int idx = 0; idx < NC; idx++) c[idx] <= '0;
    end else begin
      for (int idx = 0; idx < NC; idx++) begin
        if (clr) begin
          c[idx] <= '0;
        end else if (acc_en && (acc_k == KW'(idx))) begin
          c[idx] <= c[idx] ^ acc_val;
        end else if (red_en) begin
          if (red_k == KW'(idx))
            c[idx] <= '0;
          else if ((lo_idx == KW'(idx)) || (mid_idx == KW'(idx)))
            c[idx] <= c[idx] ^ fold;
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign coef_lo[g*W +: W] = c[g];
  end

  always_comb begin
    hi_zero = 1'b1;
    for (int idx = N; idx < NC; idx++) if (c[idx] != '0) hi_zero = 1'b0;
  end
endmodule

// File: rtl/cfm_mul299.sv
module cfm_mul299
  import cfm_pkg::*;
#(
  parameter int           W    = GW,
  parameter int           N    = NCOEF,
  parameter int           TAP  = EXTTAP,
  parameter logic [W-1:0] POLY = GPOLY,
  localparam int          FW   = W * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] op_a,
  input  logic [FW-1:0] op_b,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] product
);
  localparam int IW = $clog2(N);
  localparam int KW = $clog2(2*N-1);

  logic [FW-1:0] opa_q, opb_q;
  logic          start_acc, iss_valid, iss_fire, prod_fire, mul_ready;
  logic [IW-1:0] iss_i, iss_j;
  logic [KW-1:0] iss_k, prod_k, red_k;
  logic [W-1:0]  sel_a, sel_b, prod_val;
  logic          red_en, hi_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (start_acc) begin
      opa_q <= op_a;
      opb_q <= op_b;
    end
  end

  assign sel_a    = opa_q[iss_i*W +: W];
  assign sel_b    = opb_q[iss_j*W +: W];
  assign iss_fire = iss_valid && mul_ready;

  cfm_pair_seq #(.N(N), .IW(IW), .KW(KW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mul_ready(mul_ready), .mul_out_valid(prod_fire),
    .accept(start_acc), .iss_valid(iss_valid),
    .iss_i(iss_i), .iss_j(iss_j), .iss_k(iss_k),
    .red_en(red_en), .red_k(red_k), .busy(busy), .done(done)
  );

  cfm_ground_mul #(.W(W), .POLY(POLY), .TW(KW)) u_gmul (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iss_valid), .in_ready(mul_ready),
    .in_a(sel_a), .in_b(sel_b), .in_tag(iss_k),
    .out_valid(prod_fire), .out_prod(prod_val), .out_tag(prod_k)
  );

  cfm_coeff_acc #(.W(W), .N(N), .TAP(TAP), .KW(KW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(start_acc),
    .acc_en(prod_fire), .acc_k(prod_k), .acc_val(prod_val),
    .red_en(red_en), .red_k(red_k),
    .coef_lo(product), .hi_zero(hi_zero)
  );
endmodule

// File: rtl/cfm_mul299_chk.sv
module cfm_mul299_chk #(
  parameter int N  = 23,
  parameter int FW = 299
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [FW-1:0] product,
  input logic          start_acc,
  input logic          iss_fire,
  input logic          prod_fire,
  input logic          hi_zero,
  input logic [FW-1:0] opa_q,
  input logic [FW-1:0] opb_q
);
  int iss_cnt;
  int cyc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_cnt <= 0;
      cyc_cnt <= 0;
    end else if (start_acc) begin
      iss_cnt <= 0;
      cyc_cnt <= 1;
    end else begin
      if (iss_fire) iss_cnt <= iss_cnt + 1;
      if (busy)     cyc_cnt <= cyc_cnt + 1;
    end
  end

  a_r6_pair_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> iss_cnt == N*N);
  a_r6_prod_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    prod_fire |-> busy);
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cyc_cnt == N*N + N + 1);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r4_upper_folded: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> hi_zero);
  a_r9_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(opa_q) && $stable(opb_q));
  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_acc) |=> $stable(product));
endmodule

bind cfm_mul299 cfm_mul299_chk #(.N(N), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .product(product),
  .start_acc(start_acc), .iss_fire(iss_fire), .prod_fire(prod_fire),
  .hi_zero(hi_zero), .opa_q(opa_q), .opb_q(opb_q)
);

// File: tb/cfm_mul299_bench.sv
module cfm_mul299_bench;
  localparam int W   = 13;
  localparam int N   = 23;
  localparam int FW  = W * N;
  localparam int LAT = N*N + N + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] op_a = '0, op_b = '0;
  logic          busy, done;
  logic [FW-1:0] product;
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cfm_mul299 u_cfm_mul299 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Ground multiply: full carry-less product, then clear the high bits one at a time.
  function automatic logic [12:0] ref_gmul(input logic [12:0] a, input logic [12:0] b);
    logic [24:0] p;
    p = '0;
    for (int i = 0; i < 13; i++) if (b[i]) p = p ^ (25'(a) << i);
    for (int t = 24; t >= 13; t--) if (p[t]) p = p ^ (25'h201B << (t - 13));
    return p[12:0];
  endfunction

  function automatic logic [FW-1:0] ref_emul(input logic [FW-1:0] a, input logic [FW-1:0] b);
    logic [12:0] t [45];
    logic [FW-1:0] r;
    for (int k = 0; k < 45; k++) t[k] = '0;
    for (int k = 0; k < 45; k++)
      for (int i = 0; i < N; i++)
        if (k - i >= 0 && k - i < N) t[k] = t[k] ^ ref_gmul(a[i*W +: W], b[(k-i)*W +: W]);
    for (int k = 44; k >= N; k--) begin
      t[k-23] = t[k-23] ^ t[k];
      t[k-18] = t[k-18] ^ t[k];
      t[k] = '0;
    end
    for (int i = 0; i < N; i++) r[i*W +: W] = t[i];
    return r;
  endfunction

  function automatic logic [FW-1:0] rnd_elem();
    logic [319:0] v;
    v = {$urandom, $urandom, $urandom, $urandom, $urandom,
         $urandom, $urandom, $urandom, $urandom, $urandom};
    return v[FW-1:0];
  endfunction

  // Start one run and wait for done, counting falling edges from the accepting edge.
  task automatic run_mul(input logic [FW-1:0] a, input logic [FW-1:0] b,
                         output logic [FW-1:0] res, output int lat);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    check("R8", "busy after accept", FW'(busy), FW'(1));
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    check("R8", "busy low with done", FW'(busy), FW'(0));
    res = product;
  endtask

  task automatic t_reset();
    check("R1", "busy at reset", FW'(busy), FW'(0));
    check("R1", "done at reset", FW'(done), FW'(0));
    check("R1", "product at reset", product, '0);
  endtask

  task automatic t_ground();
    logic [FW-1:0] r; int lat;
    run_mul(FW'(13'h1000), FW'(13'h0002), r, lat);
    check("R3", "x^12*x in ground field", r, FW'(13'h001B));
    check("R7", "latency", FW'(lat), FW'(LAT));
    @(negedge clk);
    check("R7", "done is one cycle", FW'(done), FW'(0));
  endtask

  task automatic t_wrap();
    logic [FW-1:0] r, e; int lat;
    e = (FW'(1) << (21*W)) | (FW'(1) << (8*W)) | (FW'(1) << (3*W));
    run_mul(FW'(1) << (22*W), FW'(1) << (22*W), r, lat);
    check("R4", "y^22*y^22 fold", r, e);
  endtask

  task automatic t_packing();
    logic [FW-1:0] r, b; int lat;
    b = rnd_elem();
    run_mul(FW'(1), b, r, lat);
    check("R2", "one times B", r, b);
    run_mul(FW'(1) << W, FW'(5), r, lat);
    check("R2", "y times 5 lands in coefficient 1", r, FW'(5) << W);
    run_mul('0, b, r, lat);
    check("R5", "zero operand", r, '0);
  endtask

  task automatic t_random();
    logic [FW-1:0] r, a, b; int lat;
    for (int n = 0; n < 4; n++) begin
      a = rnd_elem(); b = rnd_elem();
      run_mul(a, b, r, lat);
      check("R5", "random product", r, ref_emul(a, b));
      check("R7", "random latency", FW'(lat), FW'(LAT));
    end
    run_mul('1, '1, r, lat);
    check("R5", "all-ones product", r, ref_emul('1, '1));
  endtask

  task automatic t_busy_start();
    logic [FW-1:0] a, b, r; int lat;
    a = rnd_elem(); b = rnd_elem();
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    repeat (60) begin @(negedge clk); lat++; end
    op_a = rnd_elem(); op_b = rnd_elem(); start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat++;
    op_a = rnd_elem();
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
    r = product;
    check("R9", "start while busy ignored", r, ref_emul(a, b));
    check("R9", "latency from first start", FW'(lat), FW'(LAT));
    op_a = rnd_elem(); op_b = rnd_elem();
    repeat (5) @(negedge clk);
    check("R10", "result held after done", product, r);
    check("R10", "still idle", FW'(busy), FW'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ground();
    t_wrap();
    t_packing();
    t_random();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule